// File: doc/BRIEF.md
# Static Not-Taken Fetch and Flush Controller

This block sits at the front of an in-order pipeline. It produces the fetch address stream under a fixed policy: every branch is assumed not taken, so fetch always moves on to the next sequential word. The assumption is made at fetch time, before anything is decoded. Each fetched instruction is tracked through a small occupancy model of the stages between fetch and execute. Each slot in that model holds a valid bit and the address of the instruction it carries.

The execute stage reports the outcome of each branch when it is resolved. A branch that turns out to be not taken changes nothing. A branch that is taken means the prediction was wrong. In that case, all slots holding younger instructions are invalidated in the same cycle, and fetch is redirected to the branch target. Fetch then stays idle for a fixed, configurable penalty before it resumes. Register-file and store write enables leave the block only through the valid bit of the execute slot, so a discarded instruction can never commit. Each fetch is also tagged as speculative whenever any instruction is still in flight up to and including the execute slot.

Top module: `nt_fetch_flush_ctrl`

## Requirements
- R1: While `rst_n` is low, `fetch_valid`, `ex_valid`, `flush`, `rf_we` and `st_we` are 0. After `rst_n` rises, the first valid fetch appears after the third rising clock edge, at address `RESET_VEC`. It is tagged non-speculative.
- R2: Once `fetch_valid` is 1 and no misprediction is signalled, the next cycle also fetches, at the current address plus 4.
- R3: A resolution with `res_taken`=0 while `ex_valid`=1 gives `flush`=0, does not change the address sequence, and invalidates no slot.
- R4: A resolution with `res_taken`=1 while `ex_valid`=1 raises `flush` in that cycle. The next valid fetch address is `res_target`; this redirect takes precedence over the +4 step.
- R5: After a misprediction, `fetch_valid` stays 0 for exactly `PENALTY` cycles (default 13). It returns to 1 on the following cycle.
- R6: Instructions fetched after a mispredicted branch, including the one fetched in the flush cycle, never reach the execute slot. No write enable is raised for them.
- R7: `rf_we` equals `rf_we_req` AND `ex_valid`, and `st_we` equals `st_we_req` AND `ex_valid`. The resolving branch itself still commits in its resolve cycle.
- R8: `fetch_spec` is 1 exactly when at least one slot, the execute slot included, holds a valid instruction. The first fetch after reset and the first fetch after a penalty are non-speculative.
- R9: A resolution presented while `ex_valid`=0 is ignored: no flush, no redirect, no penalty.
- R10: An instruction fetched in cycle c appears in the execute slot (`ex_valid`=1, `ex_pc` = its address) in cycle c+`NSLOT`, unless it is flushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-flop synchronizer |
| fetch_valid | output | 1 | A fetch request is issued this cycle |
| fetch_addr | output | AW | Byte address of the fetch request |
| fetch_spec | output | 1 | The request is speculative (instructions in flight) |
| res_valid | input | 1 | Execute stage presents a branch resolution |
| res_taken | input | 1 | Resolved outcome: 1 = taken (mispredicted) |
| res_target | input | AW | Branch target address |
| rf_we_req | input | 1 | Register write requested by the instruction in execute |
| st_we_req | input | 1 | Store requested by the instruction in execute |
| ex_valid | output | 1 | Execute slot holds a live instruction |
| ex_pc | output | AW | Address of the instruction in the execute slot |
| rf_we | output | 1 | Gated register-file write enable |
| st_we | output | 1 | Gated store write enable |
| flush | output | 1 | Misprediction: younger slots are discarded and fetch is redirected |

## Verification
The timing of each result is fixed:
- `flush` and the gated write enables are combinational in the cycle of the resolution or request.
- The redirect takes effect one cycle after `flush`. It then shows at the ports only after exactly `PENALTY` idle fetch cycles.
- A fetched address reaches `ex_pc` `NSLOT` cycles after it is issued.
- After reset release, the first fetch appears after the third rising edge.

The scoreboard stamps each issued fetch with the cycle it is due in execute, and compares only in that cycle. It also counts the idle fetch cycles between `flush` and resumption and compares that count with `PENALTY`. Outputs are sampled on the falling edge. Inputs change just after the rising edge, so every comparison falls in the cycle the design is meant to produce its result.

// File: rtl/nt_fetch_pkg.sv
package nt_fetch_pkg;

  // Fetch sequencer states
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,  // leaving reset, no request yet
    FS_RUN  = 2'd1,  // issuing sequential requests
    FS_HOLD = 2'd2   // misprediction penalty in progress
  } fetch_state_e;

  // Bytes per instruction word
  localparam int unsigned INSN_BYTES = 4;

endpackage

// File: rtl/nt_fetch_pc.sv
module nt_fetch_pc
  import nt_fetch_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter logic [AW-1:0] RESET_VEC = '0,
  parameter int unsigned PENALTY   = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          redirect,
  input  logic [AW-1:0] target,
  output logic          fetch_valid,
  output logic [AW-1:0] fetch_addr
);

  localparam int unsigned   CW   = $clog2(PENALTY + 1);
  localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);
  localparam logic [CW-1:0] PEN  = CW'(PENALTY);
  localparam logic [CW-1:0] ONE  = CW'(1);

  fetch_state_e  state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] pc_q, pc_d;
  logic          pc_en, cnt_en;

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    pc_d    = pc_q;
    pc_en   = 1'b0;
    cnt_en  = 1'b0;
    if (redirect) begin
      // a redirect overrides the sequential step
      pc_d    = target;
      pc_en   = 1'b1;
      cnt_d   = PEN;
      cnt_en  = 1'b1;
      state_d = FS_HOLD;
    end else begin
      unique case (state_q)
        FS_IDLE: state_d = FS_RUN;
        FS_RUN: begin
          pc_d  = pc_q + STEP;
          pc_en = 1'b1;
        end
        FS_HOLD: begin
          cnt_d  = cnt_q - ONE;
          cnt_en = 1'b1;
          if (cnt_q <= ONE) state_d = FS_RUN;
        end
        default: state_d = FS_IDLE;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= RESET_VEC;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign fetch_valid = (state_q == FS_RUN);
  assign fetch_addr  = pc_q;

endmodule

// File: rtl/nt_slot_pipe.sv
module nt_slot_pipe #(
  parameter int unsigned AW    = 32,
  parameter int unsigned NSLOT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [AW-1:0] in_pc,
  input  logic          kill,
  output logic          busy,
  output logic          ex_valid,
  output logic [AW-1:0] ex_pc
);

  localparam int unsigned LAST = NSLOT - 1;

  logic [NSLOT-1:0] v_q, v_d;
  logic [AW-1:0]    pc_q [NSLOT];
  logic [AW-1:0]    pc_d [NSLOT];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    // next state: shift toward execute; a kill empties every slot,
    // since everything behind the resolving branch is younger
    if (s == 0) begin : g_head
      always_comb begin
        v_d[s]  = in_valid & ~kill;
        pc_d[s] = in_pc;
      end
    end else begin : g_body
      always_comb begin
        v_d[s]  = v_q[s-1] & ~kill;
        pc_d[s] = pc_q[s-1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q[s] <= 1'b0;
      end else begin
        v_q[s] <= v_d[s];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pc_q[s] <= '0;
      end else if (v_d[s]) begin
        pc_q[s] <= pc_d[s];
      end
    end
  end

  assign busy     = |v_q;
  assign ex_valid = v_q[LAST];
  assign ex_pc    = pc_q[LAST];

endmodule

// File: rtl/nt_commit_gate.sv
module nt_commit_gate (
  input  logic ex_valid,
  input  logic res_valid,
  input  logic res_taken,
  input  logic rf_we_req,
  input  logic st_we_req,
  output logic mispredict,
  output logic rf_we,
  output logic st_we
);

  // a resolution counts only if a live instruction is in execute
  assign mispredict = ex_valid & res_valid & res_taken;
  assign rf_we      = ex_valid & rf_we_req;
  assign st_we      = ex_valid & st_we_req;

endmodule

// File: rtl/nt_fetch_flush_ctrl.sv
module nt_fetch_flush_ctrl #(
  parameter int unsigned   AW        = 32,
  parameter int unsigned   NSLOT     = 4,
  parameter int unsigned   PENALTY   = 13,
  parameter logic [AW-1:0] RESET_VEC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          fetch_valid,
  output logic [AW-1:0] fetch_addr,
  output logic          fetch_spec,
  input  logic          res_valid,
  input  logic          res_taken,
  input  logic [AW-1:0] res_target,
  input  logic          rf_we_req,
  input  logic          st_we_req,
  output logic          ex_valid,
  output logic [AW-1:0] ex_pc,
  output logic          rf_we,
  output logic          st_we,
  output logic          flush
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  logic busy;
  logic mispredict;

  nt_fetch_pc #(
    .AW       (AW),
    .RESET_VEC(RESET_VEC),
    .PENALTY  (PENALTY)
  ) u_pc (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .redirect   (mispredict),
    .target     (res_target),
    .fetch_valid(fetch_valid),
    .fetch_addr (fetch_addr)
  );

  nt_slot_pipe #(
    .AW   (AW),
    .NSLOT(NSLOT)
  ) u_slots (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .in_valid(fetch_valid),
    .in_pc   (fetch_addr),
    .kill    (mispredict),
    .busy    (busy),
    .ex_valid(ex_valid),
    .ex_pc   (ex_pc)
  );

  nt_commit_gate u_gate (
    .ex_valid  (ex_valid),
    .res_valid (res_valid),
    .res_taken (res_taken),
    .rf_we_req (rf_we_req),
    .st_we_req (st_we_req),
    .mispredict(mispredict),
    .rf_we     (rf_we),
    .st_we     (st_we)
  );

  assign fetch_spec = busy;
  assign flush      = mispredict;

endmodule

// File: rtl/nt_fetch_flush_chk.sv
module nt_fetch_flush_chk #(
  parameter int unsigned AW      = 32,
  parameter int unsigned PENALTY = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fetch_valid,
  input logic [AW-1:0] fetch_addr,
  input logic          fetch_spec,
  input logic          res_valid,
  input logic          res_taken,
  input logic [AW-1:0] res_target,
  input logic          ex_valid,
  input logic          rf_we,
  input logic          st_we,
  input logic          flush
);

  // counts idle fetch cycles after a misprediction
  logic        hold_q;
  logic [31:0] hold_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q     <= 1'b0;
      hold_cnt_q <= '0;
    end else if (flush) begin
      hold_q     <= 1'b1;
      hold_cnt_q <= '0;
    end else if (hold_q && fetch_valid) begin
      hold_q     <= 1'b0;
    end else if (hold_q) begin
      hold_cnt_q <= hold_cnt_q + 32'd1;
    end
  end

  a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !flush) |=> (fetch_valid && fetch_addr == $past(fetch_addr) + AW'(4)));

  a_r3_not_taken_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_taken) |-> !flush);

  a_r4_redirect_target: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fetch_addr == $past(res_target)));

  a_r5_penalty_len: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && fetch_valid) |-> (hold_cnt_q == PENALTY));

  a_r5_bubble_start: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !fetch_valid);

  a_r6_younger_gone: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !ex_valid);

  a_r7_gate_rf: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> ex_valid);

  a_r7_gate_st: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> ex_valid);

  a_r8_spec_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid |-> fetch_spec);

  a_r8_spec_clear: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !fetch_spec);

  a_r9_idle_res: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_valid |-> !flush);

endmodule

bind nt_fetch_flush_ctrl nt_fetch_flush_chk #(
  .AW     (AW),
  .PENALTY(PENALTY)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fetch_valid(fetch_valid),
  .fetch_addr (fetch_addr),
  .fetch_spec (fetch_spec),
  .res_valid  (res_valid),
  .res_taken  (res_taken),
  .res_target (res_target),
  .ex_valid   (ex_valid),
  .rf_we      (rf_we),
  .st_we      (st_we),
  .flush      (flush)
);

// File: tb/nt_fetch_flush_ctrl_test.sv
module nt_fetch_flush_ctrl_test;

  localparam int          CLK_PERIOD = 10;
  localparam int          AW         = 32;
  localparam int          NSLOT      = 4;
  localparam int          PENALTY    = 13;
  localparam logic [31:0] RVEC       = 32'h0000_0100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fetch_valid, fetch_spec, ex_valid, rf_we, st_we, flush;
  logic [AW-1:0] fetch_addr, ex_pc;
  logic          res_valid = 1'b0, res_taken = 1'b0;
  logic [AW-1:0] res_target = '0;
  logic          rf_we_req = 1'b0, st_we_req = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nt_fetch_flush_ctrl #(
    .AW(AW), .NSLOT(NSLOT), .PENALTY(PENALTY), .RESET_VEC(RVEC)
  ) uut (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_spec(fetch_spec),
    .res_valid(res_valid), .res_taken(res_taken), .res_target(res_target),
    .rf_we_req(rf_we_req), .st_we_req(st_we_req),
    .ex_valid(ex_valid), .ex_pc(ex_pc), .rf_we(rf_we), .st_we(st_we),
    .flush(flush)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard of issued fetches, each stamped with its execute cycle
  typedef struct {
    logic [31:0] addr;
    int          due;
  } rec_t;
  rec_t        sb[$];
  int          cyc        = 0;
  int          since_rel  = 0;
  bit          started    = 1'b0;
  logic [31:0] next_addr  = RVEC;
  int          bubbles    = 0;
  int          gap        = 0;
  bit          in_gap     = 1'b0;

  task automatic model_cycle();
    bit          exp_ex, exp_spec, mis, exp_fv;
    logic [31:0] exp_pc;
    exp_ex = (sb.size() > 0) && (sb[0].due == cyc);
    exp_pc = exp_ex ? sb[0].addr : 32'h0;
    chk(ex_valid == exp_ex, "R10/R6 ex_valid", 64'(ex_valid), 64'(exp_ex));
    if (exp_ex) chk(ex_pc == exp_pc, "R10 ex_pc", 64'(ex_pc), 64'(exp_pc));
    chk(rf_we == (exp_ex && rf_we_req), exp_ex ? "R7 rf_we" : "R6 rf_we",
        64'(rf_we), 64'(exp_ex && rf_we_req));
    chk(st_we == (exp_ex && st_we_req), exp_ex ? "R7 st_we" : "R6 st_we",
        64'(st_we), 64'(exp_ex && st_we_req));
    exp_spec = (sb.size() != 0);
    mis      = exp_ex && res_valid && res_taken;
    if (res_valid && !exp_ex)
      chk(flush == 1'b0, "R9 ignored resolution", 64'(flush), 64'd0);
    else if (res_valid && !res_taken)
      chk(flush == 1'b0, "R3 not-taken no flush", 64'(flush), 64'd0);
    else
      chk(flush == mis, "R4 flush", 64'(flush), 64'(mis));
    exp_fv = (bubbles == 0);
    chk(fetch_valid == exp_fv, "R5 fetch_valid", 64'(fetch_valid), 64'(exp_fv));
    if (exp_fv) begin
      chk(fetch_addr == next_addr, "R2/R4 fetch_addr", 64'(fetch_addr), 64'(next_addr));
      chk(fetch_spec == exp_spec, "R8 fetch_spec", 64'(fetch_spec), 64'(exp_spec));
      if (in_gap) begin
        chk(gap == PENALTY, "R5 penalty length", 64'(gap), 64'(PENALTY));
        in_gap = 1'b0;
      end
    end else if (in_gap) begin
      gap++;
    end
    if (exp_ex) void'(sb.pop_front());
    if (mis) begin
      sb.delete();
      next_addr = res_target;
      bubbles   = PENALTY;
      in_gap    = 1'b1;
      gap       = 0;
    end else if (exp_fv) begin
      sb.push_back('{addr: next_addr, due: cyc + NSLOT});
      next_addr = next_addr + 32'd4;
    end else if (bubbles > 0) begin
      bubbles--;
    end
  endtask

  // monitor: samples on the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        chk(!fetch_valid && !ex_valid && !flush && !rf_we && !st_we,
            "R1 reset outputs", 64'({fetch_valid, ex_valid, flush, rf_we, st_we}), 64'd0);
        since_rel = 0;
      end else if (!started) begin
        since_rel++;
        if (since_rel < 4) begin
          chk(fetch_valid == 1'b0, "R1 reset latency", 64'(fetch_valid), 64'd0);
        end else begin
          chk(fetch_valid && fetch_addr == RVEC && !fetch_spec, "R1 first fetch",
              64'(fetch_addr), 64'(RVEC));
          started = 1'b1;
          model_cycle();
        end
      end else begin
        model_cycle();
      end
      cyc++;
    end
  end

  // write-request pattern from an LFSR, changed just after each rising edge
  logic [7:0] lfsr = 8'hA5;
  initial begin
    forever begin
      @(posedge clk);
      #1;
      lfsr      = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rf_we_req = lfsr[0] | lfsr[3];
      st_we_req = lfsr[1];
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // present a resolution in the next cycle that has a live instruction in execute
  task automatic resolve(input bit taken, input logic [31:0] tgt);
    step(1);
    while (!ex_valid) step(1);
    res_valid  = 1'b1;
    res_taken  = taken;
    res_target = tgt;
    step(1);
    res_valid  = 1'b0;
    res_taken  = 1'b0;
  endtask

  // present a taken resolution while execute is empty
  task automatic resolve_idle(input logic [31:0] tgt);
    step(1);
    while (ex_valid) step(1);
    res_valid  = 1'b1;
    res_taken  = 1'b1;
    res_target = tgt;
    step(1);
    res_valid  = 1'b0;
    res_taken  = 1'b0;
  endtask

  initial begin
    step(5);
    rst_n = 1'b1;
    step(14);
    resolve(1'b0, 32'h0000_0800);   // R3
    step(3);
    resolve(1'b1, 32'h0000_1000);   // R4 R5 R6
    step(3);
    resolve_idle(32'hDEAD_0000);    // R9 during the penalty
    resolve(1'b1, 32'h0000_2000);   // mispredict on the first target instruction
    step(6);
    resolve(1'b1, 32'h0000_3004);   // R8: the resume fetch is non-speculative
    step(20);
    resolve(1'b0, 32'h0000_4000);   // R3
    step(12);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule